// File: doc/BRIEF.md
# In-Order Five-Stage Pipeline Sequencer

This block is the control spine of a scalar in-order pipeline with five stages: fetch, decode/register-read, execute, memory and writeback. Each stage takes one cycle. The block tracks which stages hold a live instruction. It produces the load enable for each stage boundary and owns the fetch program counter. The datapath registers beside it use these enables to move their contents. A single execute unit serves all arithmetic and logic work, so execute takes at most one instruction per cycle.

Decode can raise a stall request, for example on an unresolved register dependency. During the stall the decode instruction and the fetch counter hold still, execute receives an empty slot, and the older instructions in execute, memory and writeback keep draining. Halting happens in two steps. Fetching the HALT opcode stops fetch at once. The halted flag rises only after HALT itself has left writeback, so every older instruction retires first. From then on all stages stay empty until reset.

Top module: `inorder_pipe_ctrl`

## Requirements
- R1: A synchronous active-low reset empties decode, execute, memory and writeback, loads the fetch counter with START_PC, clears halted and turns fetch on.
- R2: A valid instruction in execute is valid in memory one cycle later, and a valid instruction in memory is valid in writeback one cycle later. `stage_adv` bit k is high in a cycle in which a valid instruction moves from stage k to stage k+1, where stage index 0 is fetch, 1 decode, 2 execute, 3 memory and 4 writeback. `stage_valid` uses the same bit order.
- R3: The fetch counter grows by PC_STEP in each cycle in which fetch hands an instruction to decode. In every other cycle it holds its value.
- R4: When an opcode equal to HALT_OP moves from fetch into decode, `fetch_en` is low from the next cycle until reset. A HALT opcode presented while fetch is held by a stall is not consumed, and fetch stays on.
- R5: `halted` rises in the cycle after HALT occupies writeback, and never earlier.
- R6: While decode holds a valid instruction and `dec_stall` is high, that instruction stays in decode, the fetch counter holds, and `stage_adv` bits 0 and 1 are low.
- R7: In a stall cycle execute loads an empty slot, while memory and writeback keep receiving what execute and memory held.
- R8: `dec_stall` has no effect while decode is empty: fetch still hands its instruction to decode.
- R9: Once `halted` is high it stays high, and all `stage_valid` bits and `fetch_en` stay low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_op | input | OP_W | Opcode read at `fetch_pc` in this cycle |
| dec_stall | input | 1 | Stall request from decode |
| fetch_pc | output | PC_W | Current fetch address |
| fetch_en | output | 1 | Fetch is issuing an instruction this cycle |
| stage_valid | output | 5 | Per-stage valid flags, bit 0 fetch to bit 4 writeback |
| stage_adv | output | 4 | Boundary load enables, bit k moves stage k into stage k+1 |
| halted | output | 1 | HALT has retired and the machine is stopped |

## Verification
The embedded assertions check on every cycle that the counter steps only on a transfer into decode and that a stall freezes decode and the counter while execute receives an empty slot. They also check that execute and memory contents always move on one stage, that a consumed HALT stops fetch for good, and that halted rises only right after HALT sits in writeback and then keeps the pipe empty. Only the bench's scenarios can show whole-timeline behaviour. This covers the exact valid and enable patterns of an interleaved run of stalls and HALT, the number of cycles from HALT fetch to halted, recovery through reset after a halt, and the case of a HALT that waits under a stall without being taken.

// File: rtl/pipe_seq_pkg.sv
// Shared definitions for the pipeline sequencer.
// Assumes: five stages, indexed fetch=0 through writeback=4.
package pipe_seq_pkg;

    localparam int N_STAGES = 5;
    localparam int N_LINKS  = N_STAGES - 1;

    // Per-stage occupancy record carried from stage to stage
    typedef struct packed {
        logic valid;
        logic is_halt;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{valid: 1'b0, is_halt: 1'b0};

endpackage

// File: rtl/pipe_fetch_ctl.sv
// Fetch control: owns the fetch counter and the latch that remembers a
// consumed HALT. It assumes the opcode at fetch_pc arrives in the same
// cycle, and that stall_eff is already gated by decode occupancy.
module pipe_fetch_ctl
    import pipe_seq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              OP_W     = 4,
    parameter logic [PC_W-1:0] START_PC = '0,
    parameter logic [PC_W-1:0] PC_STEP  = 4,
    parameter logic [OP_W-1:0] HALT_OP  = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] fetch_op,
    input  logic            stall_eff,
    input  logic            halted,
    output logic            fetch_en,
    output logic            take,
    output logic [PC_W-1:0] fetch_pc,
    output slot_t           fetch_slot
);

    logic halt_seen;
    logic op_is_halt;

    // Fetch is live until a HALT was handed on or the machine stopped
    always_comb begin
        op_is_halt = (fetch_op == HALT_OP);
        fetch_en   = ~halt_seen & ~halted;
        take       = fetch_en & ~stall_eff;
        fetch_slot = '{valid: fetch_en, is_halt: op_is_halt};
    end

    // Counter steps on each transfer into decode
    always_ff @(posedge clk) begin
        if (!rst_n)
            fetch_pc <= START_PC;
        else if (take)
            fetch_pc <= fetch_pc + PC_STEP;
    end

    // Remember that HALT has left fetch
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_seen <= 1'b0;
        else if (take && op_is_halt)
            halt_seen <= 1'b1;
    end

    a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> fetch_pc == $past(fetch_pc) + PC_STEP);
    a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(fetch_pc));
    a_r4_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fetch_op == HALT_OP) |=> !fetch_en);
    a_r4_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> !fetch_en);

endmodule

// File: rtl/pipe_slot_reg.sv
// One stage register of occupancy state. Assumes clear wins over hold,
// and that an empty input slot is how a bubble is loaded.
module pipe_slot_reg
    import pipe_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  clear,
    input  slot_t d,
    output slot_t q
);

    // Load, hold or empty the slot
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            q <= SLOT_EMPTY;
        else if (!hold)
            q <= d;
    end

endmodule

// File: rtl/pipe_retire_ctl.sv
// Retirement control: raises the sticky halted flag once HALT sits in
// writeback. Assumes the writeback slot advances every cycle.
module pipe_retire_ctl
    import pipe_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t wb_slot,
    output logic  halted
);

    // Sticky stop flag set on HALT retirement
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (wb_slot.valid && wb_slot.is_halt)
            halted <= 1'b1;
    end

    a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_slot.valid && wb_slot.is_halt) |=> halted);
    a_r5_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(wb_slot.valid && wb_slot.is_halt));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

endmodule

// File: rtl/inorder_pipe_ctrl.sv
// Top of the five-stage in-order pipeline sequencer. It assembles fetch
// control, the four stage slots (decode to writeback) and retirement.
// Assumes dec_stall may be high at any time and is honoured only when
// decode holds a valid instruction.
module inorder_pipe_ctrl
    import pipe_seq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              OP_W     = 4,
    parameter logic [PC_W-1:0] START_PC = 16'h0100,
    parameter logic [PC_W-1:0] PC_STEP  = 4,
    parameter logic [OP_W-1:0] HALT_OP  = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     fetch_op,
    input  logic                dec_stall,
    output logic [PC_W-1:0]     fetch_pc,
    output logic                fetch_en,
    output logic [N_STAGES-1:0] stage_valid,
    output logic [N_LINKS-1:0]  stage_adv,
    output logic                halted
);

    slot_t fetch_slot;
    slot_t in_s [1:N_LINKS];
    slot_t q_s  [1:N_LINKS];
    logic  stall_eff;
    logic  take;

    // Stall is meaningful only with an instruction in decode
    always_comb stall_eff = dec_stall & q_s[1].valid;

    pipe_fetch_ctl #(
        .PC_W(PC_W), .OP_W(OP_W), .START_PC(START_PC),
        .PC_STEP(PC_STEP), .HALT_OP(HALT_OP)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .fetch_op(fetch_op),
        .stall_eff(stall_eff), .halted(halted), .fetch_en(fetch_en),
        .take(take), .fetch_pc(fetch_pc), .fetch_slot(fetch_slot)
    );

    // Build the slot chain; decode holds on stall, execute takes a bubble
    for (genvar i = 1; i <= N_LINKS; i++) begin : g_slot
        if (i == 1) begin : g_src_fetch
            assign in_s[i] = fetch_slot;
        end else if (i == 2) begin : g_src_decode
            assign in_s[i] = stall_eff ? SLOT_EMPTY : q_s[i-1];
        end else begin : g_src_prev
            assign in_s[i] = q_s[i-1];
        end
        pipe_slot_reg u_slot (
            .clk(clk), .rst_n(rst_n),
            .hold((i == 1) ? stall_eff : 1'b0),
            .clear(halted), .d(in_s[i]), .q(q_s[i])
        );
    end

    pipe_retire_ctl u_retire (
        .clk(clk), .rst_n(rst_n), .wb_slot(q_s[N_LINKS]), .halted(halted)
    );

    // Gather per-stage flags and boundary enables
    always_comb begin
        stage_valid[0] = fetch_en;
        for (int k = 1; k < N_STAGES; k++)
            stage_valid[k] = q_s[k].valid;
        stage_adv[0] = take;
        stage_adv[1] = q_s[1].valid & ~stall_eff;
        for (int k = 2; k < N_LINKS; k++)
            stage_adv[k] = q_s[k].valid;
    end

    a_r2_ex_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
        q_s[2].valid |=> q_s[3].valid);
    a_r2_mem_to_wb: assert property (@(posedge clk) disable iff (!rst_n)
        q_s[3].valid |=> q_s[4].valid);
    a_r6_decode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && q_s[1].valid) |=> (q_s[1].valid && $stable(q_s[1]) && $stable(fetch_pc)));
    a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && q_s[1].valid) |=> !q_s[2].valid);
    a_r8_empty_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !q_s[1].valid && fetch_en) |=> q_s[1].valid);
    a_r9_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (stage_valid == '0 && !fetch_en));

endmodule

// File: tb/inorder_pipe_ctrl_tb.sv
module inorder_pipe_ctrl_tb;

    localparam int              PC_W  = 16;
    localparam int              OP_W  = 4;
    localparam logic [PC_W-1:0] START = 16'h0200;
    localparam logic [PC_W-1:0] STEP  = 16'd4;
    localparam logic [OP_W-1:0] HALT  = 4'hF;
    localparam logic [OP_W-1:0] NOP   = 4'h0;
    localparam int              NVEC  = 12;

    // {halt_op, stall, valid[4:0], adv[3:0], halted, pc_index[3:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 5'b00001, 4'b0001, 1'b0, 4'd0},
        {1'b0, 1'b0, 5'b00011, 4'b0011, 1'b0, 4'd1},
        {1'b0, 1'b1, 5'b00111, 4'b0100, 1'b0, 4'd2},
        {1'b0, 1'b0, 5'b01011, 4'b1011, 1'b0, 4'd2},
        {1'b1, 1'b0, 5'b10111, 4'b0111, 1'b0, 4'd3},
        {1'b0, 1'b1, 5'b01110, 4'b1100, 1'b0, 4'd4},
        {1'b0, 1'b0, 5'b11010, 4'b1010, 1'b0, 4'd4},
        {1'b0, 1'b1, 5'b10100, 4'b0100, 1'b0, 4'd4},
        {1'b0, 1'b0, 5'b01000, 4'b1000, 1'b0, 4'd4},
        {1'b0, 1'b0, 5'b10000, 4'b0000, 1'b0, 4'd4},
        {1'b0, 1'b0, 5'b00000, 4'b0000, 1'b1, 4'd4},
        {1'b1, 1'b1, 5'b00000, 4'b0000, 1'b1, 4'd4}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] fetch_op = NOP;
    logic            dec_stall = 1'b0;
    logic [PC_W-1:0] fetch_pc;
    logic            fetch_en;
    logic [4:0]      stage_valid;
    logic [3:0]      stage_adv;
    logic            halted;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    inorder_pipe_ctrl #(
        .PC_W(PC_W), .OP_W(OP_W), .START_PC(START), .PC_STEP(STEP), .HALT_OP(HALT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_op(fetch_op), .dec_stall(dec_stall),
        .fetch_pc(fetch_pc), .fetch_en(fetch_en), .stage_valid(stage_valid),
        .stage_adv(stage_adv), .halted(halted)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply a synchronous reset; returns at a falling edge with reset released
    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        fetch_op  = NOP;
        dec_stall = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [PC_W-1:0] pc_at(input int idx);
        return START + PC_W'(idx) * STEP;
    endfunction

    initial begin
        do_reset();
        #1;
        // R1: reset state
        chk("R1", "stage_valid", 32'(stage_valid), 32'b00001);
        chk("R1", "fetch_pc", 32'(fetch_pc), 32'(START));
        chk("R1", "halted", 32'(halted), 32'd0);

        // Vector walk: stalls, bubbles, HALT drain (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < NVEC; i++) begin
            fetch_op  = VEC[i][15] ? HALT : NOP;
            dec_stall = VEC[i][14];
            #1;
            chk("R2_R6_R7", "stage_valid", 32'(stage_valid), 32'(VEC[i][13:9]));
            chk("R2_R6_R8", "stage_adv", 32'(stage_adv), 32'(VEC[i][8:5]));
            chk("R5_R9", "halted", 32'(halted), 32'(VEC[i][4]));
            chk("R3_R4", "fetch_pc", 32'(fetch_pc), 32'(pc_at(int'(VEC[i][3:0]))));
            @(negedge clk);
        end

        // R1: reset after a halt restarts the machine
        do_reset();
        #1;
        chk("R1", "restart valid", 32'(stage_valid), 32'b00001);
        chk("R1", "restart halted", 32'(halted), 32'd0);
        chk("R1", "restart pc", 32'(fetch_pc), 32'(START));

        // R8: stall with empty decode is ignored
        dec_stall = 1'b1;
        #1;
        chk("R8", "adv with empty decode", 32'(stage_adv), 32'b0001);
        @(negedge clk);
        #1;
        chk("R8", "decode filled", 32'(stage_valid), 32'b00011);
        chk("R8", "pc stepped", 32'(fetch_pc), 32'(pc_at(1)));

        // R4/R6: HALT under stall is not consumed
        fetch_op  = HALT;
        dec_stall = 1'b1;
        #1;
        chk("R6", "fetch adv under stall", 32'(stage_adv[0]), 32'd0);
        @(negedge clk);
        #1;
        chk("R4", "fetch still on", 32'(fetch_en), 32'd1);
        chk("R6", "pc held", 32'(fetch_pc), 32'(pc_at(1)));
        dec_stall = 1'b0;
        @(negedge clk);
        #1;
        chk("R4", "fetch off after HALT", 32'(fetch_en), 32'd0);
        chk("R3", "pc after HALT", 32'(fetch_pc), 32'(pc_at(2)));

        // R5: HALT as the very first instruction
        do_reset();
        fetch_op = HALT;
        @(negedge clk);
        fetch_op = NOP;
        #1;
        chk("R4", "first HALT stops fetch", 32'(fetch_en), 32'd0);
        for (int c = 1; c <= 4; c++) begin
            #1;
            chk("R2", "HALT walk", 32'(stage_valid), 32'(5'b00001 << c));
            chk("R5", "not yet halted", 32'(halted), 32'd0);
            @(negedge clk);
        end
        #1;
        chk("R5", "halted after retire", 32'(halted), 32'd1);
        chk("R9", "pipe empty", 32'(stage_valid), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule